// File: doc/BRIEF.md
# Masked Interrupt Alert Aggregator

This block gathers fifteen out-of-limit event pulses, plus one thermal-throttle pulse that can stand in for one of them, into two sticky 8-bit status registers. Each status bit has a mask bit. A set mask bit keeps its source from driving the shared active-low alert line, but the status bit still latches. A single summary mask bit in the first mask register silences every source held in the second status register.

Software reaches the status, mask and configuration registers through a small register port. A read returns its data one cycle after the strobe. Reading a status register clears the bits that were set at that moment. An event pulse that arrives in the same cycle as the read stays latched. The alert output is off after reset until software sets the enable bit. A second configuration bit moves bit 5 of the second status register from the fan-4 failure pulse to the thermal-throttle pulse.

Register map. The address selects the register:

- 0: status A. Bits 6..0 hold the temperature and voltage sources. Bit 7 is a live summary of status B.
- 1: status B.
- 2: mask A.
- 3: mask B.
- 4: configuration. Bit 0 is the alert enable. Bit 1 is the thermal mode.

Top module: `irq_alert_agg`

## Requirements
- R1: After reset every register (addresses 0 to 4) reads 0x00 and alert_n is 1.
- R2: A one-cycle pulse on evt_a[i] sets status A bit i, and a pulse on evt_b[i] sets status B bit i. The bit stays set on following cycles until its own status register is read.
- R3: A read of address 0 or 1 returns the current value and clears the bits that were set. An event pulse on the same edge leaves its bit set, so the next read shows it.
- R4: A mask bit of 1 removes its source from the alert. The status bit still latches and reads back as 1.
- R5: Mask A bit 7 = 1 removes every status B bit from the alert.
- R6: Status A bit 7 reads 1 exactly when any status B bit is set. It is not masked, and a read of address 0 does not clear it.
- R7: alert_n = NOT(cfg bit 0 AND the OR of all status bits that are set and unmasked), taken from the registers after each edge. With cfg bit 0 = 0, alert_n stays 1.
- R8: With cfg bit 1 = 1, status B bit 5 is set by evt_therm and evt_b[5] is ignored. With cfg bit 1 = 0, evt_b[5] sets it and evt_therm is ignored.
- R9: Writes to addresses 2 and 3 store all 8 bits. Writes to address 4 store bits 1..0, and the other bits read 0. Writes to addresses 0 and 1 change nothing. Addresses 5 to 7 read 0x00.
- R10: rd_data shows the addressed value in the cycle after rd_en. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_a | input | 7 | Event pulses for status A bits 6..0 |
| evt_b | input | 8 | Event pulses for status B bits 7..0 |
| evt_therm | input | 1 | Thermal-throttle event pulse |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid one cycle after rd_en |
| alert_n | output | 1 | Alert output, active low |

## Verification
The embedded properties check every cycle that a pulse latches and then holds until a clearing read. They also check that a clearing read keeps exactly the events that land on the same edge, that a disabled alert stays high, and that the summary mask silences status B. They further check that thermal mode routes the throttle pulse to bit 5 and that mask reads return the register one cycle later. Only the bench scenarios show the full alert equation under mixed mask patterns, the live summary bit, the ignored status writes, the unmapped addresses, and the ignored fan-4 pulse in thermal mode.

// File: rtl/irq_alert_pkg.sv
package irq_alert_pkg;
   localparam int unsigned REG_DW      = 8;
   localparam int unsigned REG_AW      = 3;
   localparam int unsigned ADR_STAT_A  = 0;
   localparam int unsigned ADR_STAT_B  = 1;
   localparam int unsigned ADR_MASK_A  = 2;
   localparam int unsigned ADR_MASK_B  = 3;
   localparam int unsigned ADR_CFG     = 4;
   localparam int unsigned CFG_EN_BIT  = 0;
   localparam int unsigned CFG_THM_BIT = 1;
   localparam int unsigned CFG_W       = 2;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] evt,
   input  logic         rd_clr,
   output logic [W-1:0] stat
);
   generate
      if (W < 1) begin : g_bad_w
         $error("irq_status_bank: W must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst)
               stat[gi] <= 1'b0;
            else if (rd_clr)
               stat[gi] <= evt[gi];
            else if (evt[gi])
               stat[gi] <= 1'b1;
         end
      end
   endgenerate

   // R2: a pulse latches its bit on the next edge
   assert_evt_latch_R2: assert property (@(posedge clk) disable iff (rst)
      (|evt) |=> ((stat & $past(evt)) == $past(evt)));

   // R2: without a clearing read, set bits stay set
   assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      !rd_clr |=> ((stat & $past(stat)) == $past(stat)));

   // R3: a clearing read keeps exactly the same-edge events
   assert_clear_keep_R3: assert property (@(posedge clk) disable iff (rst)
      rd_clr |=> (stat == $past(evt)));
endmodule

// File: rtl/irq_src_route.sv
module irq_src_route #(
   parameter int unsigned W         = 8,
   parameter int unsigned THERM_BIT = 5
) (
   input  logic [W-1:0] evt_raw,
   input  logic         evt_therm,
   input  logic         therm_mode,
   output logic [W-1:0] evt_out
);
   generate
      if (THERM_BIT >= W) begin : g_bad_bit
         $error("irq_src_route: THERM_BIT out of range");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_src
         if (gi == THERM_BIT) begin : g_shared
            assign evt_out[gi] = therm_mode ? evt_therm : evt_raw[gi];
         end else begin : g_plain
            assign evt_out[gi] = evt_raw[gi];
         end
      end
   endgenerate
endmodule

// File: rtl/irq_mask_merge.sv
module irq_mask_merge #(
   parameter int unsigned W = 8
) (
   input  logic [W-2:0] stat_a,
   input  logic [W-1:0] stat_b,
   input  logic [W-1:0] mask_a,
   input  logic [W-1:0] mask_b,
   input  logic         enable,
   output logic         summary_b,
   output logic         alert_n
);
   localparam int unsigned SUM_BIT = W - 1;

   logic pend_a;
   logic pend_b;

   assign summary_b = |stat_b;
   assign pend_a    = |(stat_a & ~mask_a[W-2:0]);
   assign pend_b    = (|(stat_b & ~mask_b)) & ~mask_a[SUM_BIT];
   assign alert_n   = ~(enable & (pend_a | pend_b));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_alert_pkg::*;
#(
   parameter int unsigned W  = 8,
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [W-1:0]  wdata,
   input  logic          rd_en,
   input  logic [W-1:0]  stat_a_view,
   input  logic [W-1:0]  stat_b_view,
   output logic [W-1:0]  mask_a,
   output logic [W-1:0]  mask_b,
   output logic          cfg_en,
   output logic          cfg_thm,
   output logic          clr_a,
   output logic          clr_b,
   output logic [W-1:0]  rd_data
);
   generate
      if (AW < 3) begin : g_bad_aw
         $error("irq_reg_port: AW must hold address 4");
      end
      if (W <= CFG_W) begin : g_bad_w
         $error("irq_reg_port: W too small for config");
      end
   endgenerate

   logic hit_sa, hit_sb, hit_ma, hit_mb, hit_cf;
   logic [CFG_W-1:0] cfg_q;
   logic [W-1:0]     rd_mux;

   assign hit_sa = (addr == AW'(ADR_STAT_A));
   assign hit_sb = (addr == AW'(ADR_STAT_B));
   assign hit_ma = (addr == AW'(ADR_MASK_A));
   assign hit_mb = (addr == AW'(ADR_MASK_B));
   assign hit_cf = (addr == AW'(ADR_CFG));

   assign clr_a   = rd_en & hit_sa;
   assign clr_b   = rd_en & hit_sb;
   assign cfg_en  = cfg_q[CFG_EN_BIT];
   assign cfg_thm = cfg_q[CFG_THM_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_a <= '0;
         mask_b <= '0;
         cfg_q  <= '0;
      end else if (wr_en) begin
         if (hit_ma) mask_a <= wdata;
         if (hit_mb) mask_b <= wdata;
         if (hit_cf) cfg_q  <= wdata[CFG_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         hit_sa:  rd_mux = stat_a_view;
         hit_sb:  rd_mux = stat_b_view;
         hit_ma:  rd_mux = mask_a;
         hit_mb:  rd_mux = mask_b;
         hit_cf:  rd_mux = {{(W-CFG_W){1'b0}}, cfg_q};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_mux;
   end

   // R10: mask reads come back one cycle later
   assert_rd_mask_R10: assert property (@(posedge clk) disable iff (rst)
      (rd_en && hit_ma && !wr_en) |=> (rd_data == mask_a));

   // R10: read data holds between strobes
   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/irq_alert_agg.sv
module irq_alert_agg
   import irq_alert_pkg::*;
#(
   parameter int unsigned DW        = REG_DW,
   parameter int unsigned AW        = REG_AW,
   parameter int unsigned THERM_BIT = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-2:0] evt_a,
   input  logic [DW-1:0] evt_b,
   input  logic          evt_therm,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          alert_n
);
   localparam int unsigned SUM_BIT = DW - 1;

   logic [DW-2:0] stat_a;
   logic [DW-1:0] stat_b;
   logic [DW-1:0] evt_b_eff;
   logic [DW-1:0] mask_a, mask_b;
   logic          cfg_en, cfg_thm, clr_a, clr_b, summary_b;

   irq_src_route #(.W(DW), .THERM_BIT(THERM_BIT)) u_route (
      .evt_raw(evt_b), .evt_therm(evt_therm), .therm_mode(cfg_thm),
      .evt_out(evt_b_eff));

   irq_status_bank #(.W(DW-1)) u_bank_a (
      .clk(clk), .rst(rst), .evt(evt_a), .rd_clr(clr_a), .stat(stat_a));

   irq_status_bank #(.W(DW)) u_bank_b (
      .clk(clk), .rst(rst), .evt(evt_b_eff), .rd_clr(clr_b), .stat(stat_b));

   irq_reg_port #(.W(DW), .AW(AW)) u_regs (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .stat_a_view({summary_b, stat_a}), .stat_b_view(stat_b),
      .mask_a(mask_a), .mask_b(mask_b), .cfg_en(cfg_en), .cfg_thm(cfg_thm),
      .clr_a(clr_a), .clr_b(clr_b), .rd_data(rd_data));

   irq_mask_merge #(.W(DW)) u_merge (
      .stat_a(stat_a), .stat_b(stat_b), .mask_a(mask_a), .mask_b(mask_b),
      .enable(cfg_en), .summary_b(summary_b), .alert_n(alert_n));

   // R1: reset empties the status registers
   assert_rst_clear_R1: assert property (@(posedge clk)
      rst |=> (stat_a == '0 && stat_b == '0 && !cfg_en));

   // R7: a disabled alert never drives low
   assert_disabled_high_R7: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |-> alert_n);

   // R5: the summary mask silences status B
   assert_summary_mask_R5: assert property (@(posedge clk) disable iff (rst)
      (mask_a[SUM_BIT] && ((stat_a & ~mask_a[DW-2:0]) == '0)) |-> alert_n);

   // R8: thermal mode routes the throttle pulse to the shared bit
   assert_therm_route_R8: assert property (@(posedge clk) disable iff (rst)
      (cfg_thm && evt_therm) |=> stat_b[THERM_BIT]);
endmodule

// File: tb/irq_alert_agg_bench.sv
module irq_alert_agg_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] evt_a = '0;
   logic [7:0] evt_b = '0;
   logic       evt_therm = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       alert_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [6:0] m_sa;
   logic [7:0] m_sb, m_ma, m_mb;
   logic [1:0] m_cfg;

   always #10 clk = ~clk;

   irq_alert_agg u_irq_alert_agg (
      .clk(clk), .rst(rst), .evt_a(evt_a), .evt_b(evt_b), .evt_therm(evt_therm),
      .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
      .rd_data(rd_data), .alert_n(alert_n));

   function automatic logic exp_alert_n();
      logic pa, pb;
      pa = |(m_sa & ~m_ma[6:0]);
      pb = (|(m_sb & ~m_mb)) & ~m_ma[7];
      return ~(m_cfg[0] & (pa | pb));
   endfunction

   function automatic logic [7:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0: return {|m_sb, m_sa};
         3'd1: return m_sb;
         3'd2: return m_ma;
         3'd3: return m_mb;
         3'd4: return {6'd0, m_cfg};
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [6:0] ea, input logic [7:0] eb, input logic et,
                       input logic we, input logic [2:0] ad, input logic [7:0] wd,
                       input logic re, input string tag);
      logic [7:0] exp_rd;
      logic [7:0] ebe;
      evt_a = ea; evt_b = eb; evt_therm = et;
      wr_en = we; addr = ad; wdata = wd; rd_en = re;
      @(posedge clk);
      exp_rd = exp_read(ad);
      ebe = eb;
      if (m_cfg[1]) ebe[5] = et;
      if (re && ad == 3'd0) m_sa = ea; else m_sa = m_sa | ea;
      if (re && ad == 3'd1) m_sb = ebe; else m_sb = m_sb | ebe;
      if (we) begin
         if (ad == 3'd2) m_ma = wd;
         if (ad == 3'd3) m_mb = wd;
         if (ad == 3'd4) m_cfg = wd[1:0];
      end
      @(negedge clk);
      evt_a = '0; evt_b = '0; evt_therm = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      check({tag, " alert"}, {7'd0, alert_n}, {7'd0, exp_alert_n()});
      if (re) check({tag, " read"}, rd_data, exp_rd);
   endtask

   task automatic rd(input logic [2:0] ad, input string tag);
      step('0, '0, 1'b0, 1'b0, ad, '0, 1'b1, tag);
   endtask

   task automatic wr(input logic [2:0] ad, input logic [7:0] d, input string tag);
      step('0, '0, 1'b0, 1'b1, ad, d, 1'b0, tag);
   endtask

   task automatic idle(input string tag);
      step('0, '0, 1'b0, 1'b0, 3'd7, '0, 1'b0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1D0C));
      m_sa = '0; m_sb = '0; m_ma = '0; m_mb = '0; m_cfg = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1 alert", {7'd0, alert_n}, 8'h01);
      for (int a = 0; a < 5; a++) rd(3'(a), "R1");

      // R2, R7: latch and hold, then enable
      step(7'h08, '0, 1'b0, 1'b0, 3'd7, '0, 1'b0, "R2");
      idle("R7 disabled");
      wr(3'd4, 8'hFD, "R9 cfg");           // only bit 0 kept
      rd(3'd4, "R9 cfg readback");
      idle("R2 hold"); idle("R7 hold");

      // R3: clear with simultaneous event
      step(7'h08, '0, 1'b0, 1'b0, 3'd0, '0, 1'b1, "R3 read+event");
      rd(3'd0, "R3 survivor");
      rd(3'd0, "R3 cleared");

      // R4: masked source still latches
      wr(3'd2, 8'h04, "R4");
      step(7'h04, '0, 1'b0, 1'b0, 3'd7, '0, 1'b0, "R4 masked");
      rd(3'd0, "R4 status");

      // R5, R6: summary mask over status B
      wr(3'd2, 8'h80, "R5");
      step('0, 8'h02, 1'b0, 1'b0, 3'd7, '0, 1'b0, "R5 silenced");
      rd(3'd0, "R6 summary");
      rd(3'd0, "R6 not cleared");
      wr(3'd2, 8'h00, "R5 unmask");
      wr(3'd3, 8'h02, "R4 mask B");
      wr(3'd3, 8'h00, "R4 unmask B");
      rd(3'd1, "R3 clear B");

      // R8: thermal routing
      step('0, 8'h20, 1'b0, 1'b0, 3'd7, '0, 1'b0, "R8 fan4");
      rd(3'd1, "R8 fan4 status");
      wr(3'd4, 8'h03, "R8 mode");
      step('0, 8'h20, 1'b0, 1'b0, 3'd7, '0, 1'b0, "R8 fan4 ignored");
      rd(3'd1, "R8 ignored status");
      step('0, '0, 1'b1, 1'b0, 3'd7, '0, 1'b0, "R8 therm");
      rd(3'd1, "R8 therm status");
      wr(3'd4, 8'h01, "R8 mode off");
      step('0, '0, 1'b1, 1'b0, 3'd7, '0, 1'b0, "R8 therm ignored");
      rd(3'd1, "R8 therm ignored status");

      // R9: status writes ignored, unmapped reads zero
      step(7'h01, '0, 1'b0, 1'b0, 3'd7, '0, 1'b0, "R9 seed");
      wr(3'd0, 8'h00, "R9 wr statA");
      wr(3'd1, 8'hFF, "R9 wr statB");
      rd(3'd0, "R9 statA kept");
      rd(3'd1, "R9 statB kept");
      wr(3'd6, 8'hFF, "R9 wr unmapped");
      for (int a = 5; a < 8; a++) rd(3'(a), "R9 unmapped");

      // Random mix, R7 R3 R10
      for (int k = 0; k < 4000; k++) begin
         logic [6:0] ea;
         logic [7:0] eb;
         logic et, we, re;
         logic [2:0] ad;
         ea = 7'($urandom & $urandom & $urandom);
         eb = 8'($urandom & $urandom & $urandom);
         et = ($urandom % 6) == 0;
         we = ($urandom % 6) == 0;
         re = ($urandom % 4) == 0;
         ad = 3'($urandom);
         step(ea, eb, et, we, ad, 8'($urandom), re, "R7 R3 R10 random");
      end
      finish_run();
   end
endmodule